// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sets the length of every memory or I/O access cycle on a 20-bit address bus. The CPU starts an access with a one-clock `acc_start` pulse. With that pulse it gives the upper address bits, the access kind and the direction. The block then drives the matching active-low strobe (`rd_n` or `wr_n`). The strobe stays low for one base clock plus the number of wait states chosen for that access. `ready` is high on the last low clock, which tells the CPU the cycle ends there.

The wait policy depends on the address region and on the kind of target. The low 64 KiB (address bits 19:16 all zero) takes its mode from one configuration field. Every other address takes its mode from a second field. A mode gives either a fixed count of 0, 1 or 2 wait states, or hands control to an external active-low `wait_n` pin.

A fast-fetch option removes all waits from internal ROM and internal RAM accesses. Without it, internal ROM follows the low-region timing. Internal register (SFR) accesses always get a fixed wait count set by the block, whatever the configuration says.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset `rd_n` and `wr_n` are high and `ready` is low. Both region modes reset to 00 and fast fetch resets to off, so an external access or an internal ROM access made before any configuration write holds its strobe low for exactly one clock.
- R2: An `acc_start` sampled while idle pulls `rd_n` low (when `acc_write`=0) or `wr_n` low (when `acc_write`=1) from the next clock on. The other strobe stays high.
- R3: The strobe stays low for 1 + N clocks, where N is the wait count of the access. `ready` is high only on the last low clock, and both strobes are high on the clock after it.
- R4: Access kind encoding is 00 external, 01 internal ROM, 10 internal RAM, 11 SFR. An external access with `acc_page`=0 uses the low-region mode, and any other page uses the high-region mode. Mode 00, 01 and 10 give 0, 1 and 2 wait states.
- R5: Mode 11 means external control. The strobe stays low for the base clock plus at least one wait clock. It keeps being extended while `wait_n` is low at a rising edge during a wait clock, and it is released on the clock after `wait_n` is sampled high.
- R6: With fast fetch on, internal ROM and internal RAM accesses get zero wait states in every mode and region.
- R7: With fast fetch off, an internal ROM access uses the low-region mode whatever its page. An internal RAM access uses the mode of its address region.
- R8: An SFR access always gets exactly one wait state, whatever the mode fields and the fast-fetch setting.
- R9: An `acc_start` that arrives while a strobe is low is ignored. No second strobe follows the running access.
- R10: Configuration write: with `cfg_wr`=1, `cfg_sel`=0 loads the low-region mode from `cfg_wdata`, 1 loads the high-region mode, 2 sets fast fetch on when `cfg_wdata` is non-zero and off when it is zero, and 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration field select |
| cfg_wdata | input | 2 | Configuration write data |
| acc_start | input | 1 | One-clock access request |
| acc_page | input | 4 | Address bits 19:16 of the access |
| acc_kind | input | 2 | Access target kind |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| wait_n | input | 1 | External wait request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ready | output | 1 | High on the last clock of the strobe-low period |

## Verification
The hardest case to reach from the ports is an externally controlled cycle whose length depends on the exact clock at which `wait_n` rises. The pin is only sampled during wait clocks, and `ready` follows it within the same clock. The bench counts the low clocks of the strobe and moves `wait_n` at the falling edge before each wait clock. It holds the pin low for a set number of wait clocks, including zero, so both the minimum single wait and longer extensions are measured. A second hard case is a request that arrives mid-access. The bench injects it on a low clock and then watches the idle strobes for several clocks.

// File: rtl/bus_wait_pkg.sv
// Shared types for the bus wait-state controller.
// Assumes a 2-bit mode field per address region.
package bus_wait_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [1:0] {
        KIND_EXT  = 2'b00,
        KIND_IROM = 2'b01,
        KIND_IRAM = 2'b10,
        KIND_SFR  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        MODE_W0  = 2'b00,
        MODE_W1  = 2'b01,
        MODE_W2  = 2'b10,
        MODE_EXT = 2'b11
    } wait_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_BASE  = 2'b01,
        ST_WPROG = 2'b10,
        ST_WEXT  = 2'b11
    } seq_state_e;

    typedef struct packed {
        logic             ext;
        logic [CNT_W-1:0] cnt;
    } wait_plan_t;

endpackage

// File: rtl/bus_wait_cfg.sv
// Holds the two region mode fields and the fast-fetch enable.
// Assumes a write is one clock of cfg_wr; select 3 is unused and writes nothing.
module bus_wait_cfg
    import bus_wait_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_sel,
    input  logic [1:0] cfg_wdata,
    output wait_mode_e lo_mode,
    output wait_mode_e hi_mode,
    output logic       fast_on
);

    localparam logic [1:0] SEL_LO   = 2'd0;
    localparam logic [1:0] SEL_HI   = 2'd1;
    localparam logic [1:0] SEL_FAST = 2'd2;

    // Register updates from the configuration write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_mode <= MODE_W0;
            hi_mode <= MODE_W0;
            fast_on <= 1'b0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_LO:   lo_mode <= wait_mode_e'(cfg_wdata);
                SEL_HI:   hi_mode <= wait_mode_e'(cfg_wdata);
                SEL_FAST: fast_on <= |cfg_wdata;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/bus_wait_policy.sv
// Works out the wait plan for one access from its page, kind and the configuration.
// Purely combinational; the sequencer latches the result at access start.
module bus_wait_policy
    import bus_wait_pkg::*;
#(
    parameter int PAGE_W    = 4,
    parameter int SFR_WAITS = 1
) (
    input  logic [PAGE_W-1:0] acc_page,
    input  acc_kind_e         acc_kind,
    input  wait_mode_e        lo_mode,
    input  wait_mode_e        hi_mode,
    input  logic              fast_on,
    output wait_plan_t        plan
);

    localparam logic [CNT_W-1:0] SFR_CNT = CNT_W'(SFR_WAITS);

    logic       in_low;
    wait_mode_e region_mode;
    wait_mode_e eff_mode;

    // Region decode: the low 64 KiB is the page with all upper bits zero.
    always_comb begin
        in_low      = (acc_page == '0);
        region_mode = in_low ? lo_mode : hi_mode;
    end

    // Mode choice by target kind.
    always_comb begin
        case (acc_kind)
            KIND_IROM: eff_mode = lo_mode;
            default:   eff_mode = region_mode;
        endcase
    end

    // Final plan: SFR forced, fast fetch bypass, else mode translation.
    always_comb begin
        plan = '0;
        if (acc_kind == KIND_SFR) begin
            plan.cnt = SFR_CNT;
        end else if (fast_on && (acc_kind == KIND_IROM || acc_kind == KIND_IRAM)) begin
            plan.cnt = '0;
        end else if (eff_mode == MODE_EXT) begin
            plan.ext = 1'b1;
            plan.cnt = CNT_W'(1);
        end else begin
            plan.cnt = CNT_W'(eff_mode);
        end
    end

endmodule

// File: rtl/bus_wait_seq.sv
// Runs the strobe-low period: one base clock, then programmed or pin-controlled waits.
// Assumes acc_start is a one-clock pulse; requests seen while busy are dropped.
module bus_wait_seq
    import bus_wait_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_start,
    input  logic       acc_write,
    input  wait_plan_t plan,
    input  logic       wait_n,
    output logic       rd_n,
    output logic       wr_n,
    output logic       ready
);

    seq_state_e       state;
    wait_plan_t       held;
    logic [CNT_W-1:0] remain;
    logic             is_wr;
    logic             busy;

    // State, held plan and wait countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            held   <= '0;
            remain <= '0;
            is_wr  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (acc_start) begin
                    state <= ST_BASE;
                    held  <= plan;
                    is_wr <= acc_write;
                end
                ST_BASE: begin
                    remain <= held.cnt;
                    if (held.ext)            state <= ST_WEXT;
                    else if (held.cnt == '0) state <= ST_IDLE;
                    else                     state <= ST_WPROG;
                end
                ST_WPROG: begin
                    if (remain == CNT_W'(1)) state <= ST_IDLE;
                    remain <= remain - CNT_W'(1);
                end
                ST_WEXT: if (wait_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Strobe outputs and the last-clock ready flag.
    always_comb begin
        busy  = (state != ST_IDLE);
        rd_n  = !(busy && !is_wr);
        wr_n  = !(busy && is_wr);
        ready = ((state == ST_BASE) && !held.ext && (held.cnt == '0)) ||
                ((state == ST_WPROG) && (remain == CNT_W'(1))) ||
                ((state == ST_WEXT) && wait_n);
    end

endmodule

// File: rtl/bus_wait_ctrl.sv
// Top of the wait-state controller: configuration, policy decode and strobe sequencer.
// Assumes acc_page carries address bits 19:16 of a 20-bit bus.
module bus_wait_ctrl
    import bus_wait_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int LOW_BITS  = 16,
    parameter int SFR_WAITS = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [1:0]               cfg_sel,
    input  logic [1:0]               cfg_wdata,
    input  logic                     acc_start,
    input  logic [ADDR_W-LOW_BITS-1:0] acc_page,
    input  logic [1:0]               acc_kind,
    input  logic                     acc_write,
    input  logic                     wait_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     ready
);

    localparam int PAGE_W = ADDR_W - LOW_BITS;

    wait_mode_e lo_mode;
    wait_mode_e hi_mode;
    logic       fast_on;
    wait_plan_t plan;

    bus_wait_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .lo_mode   (lo_mode),
        .hi_mode   (hi_mode),
        .fast_on   (fast_on)
    );

    bus_wait_policy #(
        .PAGE_W    (PAGE_W),
        .SFR_WAITS (SFR_WAITS)
    ) u_policy (
        .acc_page (acc_page),
        .acc_kind (acc_kind_e'(acc_kind)),
        .lo_mode  (lo_mode),
        .hi_mode  (hi_mode),
        .fast_on  (fast_on),
        .plan     (plan)
    );

    bus_wait_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_start (acc_start),
        .acc_write (acc_write),
        .plan      (plan),
        .wait_n    (wait_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .ready     (ready)
    );

endmodule

// File: rtl/bus_wait_ctrl_chk.sv
// Port-level properties of the wait-state controller, bound to the top module.
module bus_wait_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic acc_start,
    input logic rd_n,
    input logic wr_n,
    input logic ready
);

    // Only one strobe may be low at a time (R2).
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // A strobe only falls after a request was presented (R2).
    assert_fall_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(acc_start));

    // Ready is only raised while a strobe is low (R3).
    assert_ready_in_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!rd_n || !wr_n));

    // After ready both strobes are released (R3).
    assert_release_after_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (rd_n && wr_n));

    // A low read strobe without ready stays low into the next clock (R3).
    assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);

    // A low write strobe without ready stays low into the next clock (R3).
    assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !ready) |=> !wr_n);

endmodule

bind bus_wait_ctrl bus_wait_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ready     (ready)
);

// File: tb/bus_wait_ctrl_bench.sv
module bus_wait_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [1:0] cfg_wdata = 2'd0;
    logic       acc_start = 1'b0;
    logic [3:0] acc_page = 4'd0;
    logic [1:0] acc_kind = 2'd0;
    logic       acc_write = 1'b0;
    logic       wait_n = 1'b1;
    logic       rd_n, wr_n, ready;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    bus_wait_ctrl u_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .acc_start(acc_start), .acc_page(acc_page),
        .acc_kind(acc_kind), .acc_write(acc_write), .wait_n(wait_n),
        .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
    );

    // Vector: page, kind, write, lo mode, hi mode, fast, hold clocks, expected low clocks, requirement
    typedef struct packed {
        logic [3:0] page;
        logic [1:0] kind;
        logic       wr;
        logic [1:0] lo;
        logic [1:0] hi;
        logic       fast;
        logic [2:0] hold;
        logic [3:0] exp_low;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 2'b00, 1'b0, 2'd1, 2'd0, 1'b0, 3'd0, 4'd2, 4'd4},  // R4 low region 1 wait
        '{4'h2, 2'b00, 1'b1, 2'd0, 2'd2, 1'b0, 3'd0, 4'd3, 4'd4},  // R4 high region 2 waits
        '{4'h0, 2'b00, 1'b0, 2'd2, 2'd0, 1'b0, 3'd0, 4'd3, 4'd4},  // R4 top of low region
        '{4'h1, 2'b00, 1'b0, 2'd2, 2'd0, 1'b0, 3'd0, 4'd1, 4'd4},  // R4 first high page
        '{4'h1, 2'b01, 1'b0, 2'd1, 2'd2, 1'b0, 3'd0, 4'd2, 4'd7},  // R7 ROM uses low mode
        '{4'h0, 2'b01, 1'b0, 2'd2, 2'd2, 1'b1, 3'd0, 4'd1, 4'd6},  // R6 ROM fast
        '{4'h3, 2'b10, 1'b1, 2'd2, 2'd2, 1'b1, 3'd0, 4'd1, 4'd6},  // R6 RAM fast
        '{4'h3, 2'b10, 1'b0, 2'd0, 2'd2, 1'b0, 3'd0, 4'd3, 4'd7},  // R7 RAM region mode
        '{4'h0, 2'b11, 1'b0, 2'd0, 2'd0, 1'b0, 3'd0, 4'd2, 4'd8},  // R8 SFR with modes 00
        '{4'h5, 2'b11, 1'b1, 2'd2, 2'd3, 1'b1, 3'd2, 4'd2, 4'd8},  // R8 SFR ignores all
        '{4'h4, 2'b00, 1'b0, 2'd0, 2'd3, 1'b0, 3'd0, 4'd2, 4'd5},  // R5 minimum one wait
        '{4'h0, 2'b00, 1'b1, 2'd3, 2'd0, 1'b0, 3'd3, 4'd5, 4'd5},  // R5 held three clocks
        '{4'h7, 2'b01, 1'b0, 2'd3, 2'd0, 1'b0, 3'd1, 4'd3, 4'd5},  // R5 ROM via low ext
        '{4'h0, 2'b00, 1'b1, 2'd0, 2'd1, 1'b0, 3'd0, 4'd1, 4'd4}   // R4 mode 00 no wait
    };

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [1:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Runs one access, counting strobe-low clocks and checking ready and the idle strobe.
    task automatic run_access(input logic [3:0] page, input logic [1:0] kind, input logic wr,
                              input int hold, output int lows, output bit rdy_ok, output bit pin_ok);
        bit seen_rdy;
        bit last_rdy;
        @(negedge clk);
        acc_page = page; acc_kind = kind; acc_write = wr; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        lows = 0; rdy_ok = 1'b1; pin_ok = 1'b1; seen_rdy = 1'b0; last_rdy = 1'b0;
        for (int i = 1; i < 40; i++) begin
            wait_n = (i >= hold + 2);
            #1;
            if ((wr ? rd_n : wr_n) == 1'b0) pin_ok = 1'b0;
            if ((wr ? wr_n : rd_n) == 1'b1) break;
            if (seen_rdy) rdy_ok = 1'b0;
            lows++;
            seen_rdy = ready;
            last_rdy = ready;
            @(negedge clk);
        end
        if (!last_rdy) rdy_ok = 1'b0;
        if (ready) rdy_ok = 1'b0;
        wait_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lows;
        bit rdy_ok, pin_ok;

        repeat (3) @(negedge clk);
        #1;
        // R1: outputs during and after reset
        check(rd_n && wr_n && !ready, "R1", "strobes idle in reset", {rd_n, wr_n, ready}, 3'b110);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(rd_n && wr_n && !ready, "R1", "strobes idle after reset", {rd_n, wr_n, ready}, 3'b110);

        // R1: reset modes give single-clock cycles for external and internal ROM
        run_access(4'h9, 2'b00, 1'b0, 0, lows, rdy_ok, pin_ok);
        check(lows == 1, "R1", "external low clocks after reset", lows, 1);
        run_access(4'h2, 2'b01, 1'b0, 0, lows, rdy_ok, pin_ok);
        check(lows == 1, "R1", "ROM low clocks after reset", lows, 1);

        // Table walk: R2, R3 checked on every entry, plus the requirement in the vector
        for (int v = 0; v < NV; v++) begin
            cfg_write(2'd0, VECS[v].lo);
            cfg_write(2'd1, VECS[v].hi);
            cfg_write(2'd2, {1'b0, VECS[v].fast});
            run_access(VECS[v].page, VECS[v].kind, VECS[v].wr, int'(VECS[v].hold), lows, rdy_ok, pin_ok);
            check(lows == int'(VECS[v].exp_low), $sformatf("R%0d", VECS[v].req),
                  $sformatf("vector %0d low clocks", v), lows, VECS[v].exp_low);
            check(rdy_ok, "R3", $sformatf("vector %0d ready on last clock only", v), rdy_ok, 1);
            check(pin_ok, "R2", $sformatf("vector %0d other strobe idle", v), pin_ok, 1);
        end

        // R10: select 3 writes nothing; low mode stays 2
        cfg_write(2'd0, 2'd2);
        cfg_write(2'd3, 2'd0);
        cfg_write(2'd2, 2'd0);
        run_access(4'h0, 2'b00, 1'b0, 0, lows, rdy_ok, pin_ok);
        check(lows == 3, "R10", "select 3 leaves mode", lows, 3);
        // R10: fast enable by non-zero data 2
        cfg_write(2'd2, 2'd2);
        run_access(4'h0, 2'b01, 1'b0, 0, lows, rdy_ok, pin_ok);
        check(lows == 1, "R10", "fast enabled by data 2", lows, 1);

        // R9: request while busy is dropped
        cfg_write(2'd2, 2'd0);
        @(negedge clk);
        acc_page = 4'h0; acc_kind = 2'b00; acc_write = 1'b0; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        @(negedge clk);
        acc_write = 1'b1; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        begin
            int low_seen = 0;
            for (int k = 0; k < 4; k++) begin
                #1;
                if (!wr_n) low_seen++;
                @(negedge clk);
            end
            check(low_seen == 0, "R9", "write strobe after dropped request", low_seen, 0);
        end

        // R1: reset during an access releases the strobe and clears configuration
        cfg_write(2'd1, 2'd2);
        @(negedge clk);
        acc_page = 4'h8; acc_kind = 2'b00; acc_write = 1'b0; acc_start = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(rd_n && !ready, "R1", "reset mid access", {rd_n, ready}, 2'b10);
        rst_n = 1'b1;
        run_access(4'h8, 2'b00, 1'b0, 0, lows, rdy_ok, pin_ok);
        check(lows == 1, "R1", "high mode cleared by reset", lows, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule